// File: doc/BRIEF.md
# Decode-Stage Next-PC Unit

This block works out the address of the next instruction for a 32-bit load/store core that resolves control transfers in the decode stage. Each step it takes the address of the instruction now in decode, the decoded control flags, the 26-bit jump index, the 16-bit branch offset and the two source operand values. It produces the next fetch address, together with one indicator for each kind of redirect. For link instructions it also gives the return address to write into register 31.

Six conditional branch kinds come from one comparator. The comparator checks either equality of the two operands or the sign and zero state of the first operand, and an invert flag can flip its result. A parameter selects when control takes effect. With it clear, control applies in the same step. With it set, one branch delay slot is added: the control decoded in one step is held in a register and steers the address one step later, while the instruction in the slot runs. A stall input freezes the address and the held control.

Top module: `npc_unit`

## Requirements
- R1: With no jump and no taken branch, and no stall, `npc_o` equals `pc_i + 4`, wrapping modulo 2^32, and `taken_o`, `jump_o` and `jreg_o` are all 0.
- R2: An applied jump with `jreg_i`=0 gives `npc_o = {pc_i[31:28], jidx_i, 2'b00}` and raises `jump_o`.
- R3: An applied jump with `jreg_i`=1 gives `npc_o` equal to the applied rs value and raises `jreg_o`.
- R4: The base branch condition is rs == rt when `cmp_rt_i`=1. When `cmp_rt_i`=0, it is signed rs < 0 if `le_sel_i`=0 and signed rs <= 0 if `le_sel_i`=1.
- R5: `invert_i`=1 complements the base condition. This gives not-equal, greater-or-equal-zero and greater-than-zero.
- R6: A taken branch gives `npc_o = pc_i + (sign-extended imm_i << 2)` and raises `taken_o`.
- R7: When `jump_i` and `branch_i` are both set, the jump wins: `npc_o` is the jump target and `taken_o` stays 0.
- R8: `link_en_o` follows `link_i`, and `link_val_o` equals `pc_i + 8` in both parameter settings.
- R9: With `DELAY_SLOT`=1, the control and operands present in one unstalled step steer `npc_o` in the next step, relative to the `pc_i` of that next step.
- R10: With `DELAY_SLOT`=1, reset clears the held control to a no-op, so the first step after reset gives `pc_i + 4`.
- R11: While `stall_i`=1, `npc_o` equals `pc_i` and all three indicators are 0. With `DELAY_SLOT`=1, the held control keeps its value across stalled edges.
- R12: At most one of `taken_o`, `jump_o` and `jreg_o` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze next address and held control |
| pc_i | input | 32 | Address of the instruction in decode |
| jump_i | input | 1 | Unconditional jump |
| jreg_i | input | 1 | Jump target taken from rs |
| branch_i | input | 1 | Conditional branch |
| cmp_rt_i | input | 1 | Compare rs with rt for equality |
| le_sel_i | input | 1 | Sign test includes zero |
| invert_i | input | 1 | Complement the branch condition |
| link_i | input | 1 | Instruction writes return address |
| jidx_i | input | 26 | Jump index field |
| imm_i | input | 16 | Branch offset in words |
| rs_i | input | 32 | First source operand value |
| rt_i | input | 32 | Second source operand value |
| npc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Conditional branch taken |
| jump_o | output | 1 | Absolute jump applied |
| jreg_o | output | 1 | Register jump applied |
| link_en_o | output | 1 | Return address is valid |
| link_val_o | output | 32 | Return address pc_i + 8 |

## Verification
The bench tests the comparator edges: rs equal to zero, rs of 0x80000000 and rs of 0x7FFFFFFF. If the zero test were misplaced, less-equal and greater-than would flip at zero. If the sign test were unsigned, the most-negative value would read as large. It drives the most-negative offset 0x8000, which catches a missing sign extension because the target would land 128 KiB forward instead of back. It drives a jump with the branch flag also set, and an address that wraps at 0xFFFFFFFC. In delay mode, it checks the one-step lag, the no-op after reset and a stall between load and use. A design that did not hold its register during a stall would lose the branch that was waiting in the slot.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN   = 32;
    localparam int JIDX_W = 26;
    localparam int IMM_W  = 16;
    localparam int REGION_W = XLEN - JIDX_W - 2;
    localparam int EXT_W    = XLEN - IMM_W - 2;

    typedef logic [XLEN-1:0] word_t;

    typedef struct packed {
        logic jump;
        logic jreg;
        logic branch;
        logic cmp_rt;
        logic le_sel;
        logic invert;
    } ctrl_t;

    typedef struct packed {
        ctrl_t             c;
        logic [JIDX_W-1:0] jidx;
        logic [IMM_W-1:0]  imm;
        word_t             rs;
        word_t             rt;
    } op_t;

    localparam op_t   NOP_OP   = '0;
    localparam word_t SEQ_STEP = word_t'(4);
    localparam word_t LINK_OFS = word_t'(8);

    function automatic word_t abs_target(word_t pc, logic [JIDX_W-1:0] idx);
        return {pc[XLEN-1 -: REGION_W], idx, 2'b00};
    endfunction

    function automatic word_t branch_ofs(logic [IMM_W-1:0] imm);
        return {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    endfunction

endpackage

// File: rtl/npc_ctrl_sel.sv
module npc_ctrl_sel
    import npc_pkg::*;
#(
    parameter bit DELAY_SLOT = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic stall_i,
    input  op_t  op_i,
    output op_t  op_o
);

    op_t held_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            held_q <= NOP_OP;
        else if (!stall_i)
            held_q <= op_i;
    end

    generate
        if (DELAY_SLOT) begin : g_delayed
            assign op_o = held_q;
        end else begin : g_direct
            assign op_o = op_i;
        end
    endgenerate

    // R10
    clear_on_reset_chk: assert property (@(posedge clk_i)
        rst_i |=> (held_q == NOP_OP));

    // R11
    hold_in_stall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_i |=> $stable(held_q));

    // R9
    load_when_free_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !stall_i |=> (held_q == $past(op_i)));

endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
(
    input  op_t  op_i,
    output logic cond_o
);

    logic eq;
    logic neg;
    logic zero;
    logic base;

    always_comb begin
        eq   = (op_i.rs == op_i.rt);
        neg  = op_i.rs[XLEN-1];
        zero = (op_i.rs == '0);
        if (op_i.c.cmp_rt)
            base = eq;
        else if (op_i.c.le_sel)
            base = neg | zero;
        else
            base = neg;
        cond_o = base ^ op_i.c.invert;
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  op_t   op_i,
    input  logic  cond_i,
    input  word_t pc_i,
    input  logic  stall_i,
    output word_t npc_o,
    output logic  taken_o,
    output logic  jump_o,
    output logic  jreg_o
);

    always_comb begin
        npc_o   = pc_i + SEQ_STEP;
        taken_o = 1'b0;
        jump_o  = 1'b0;
        jreg_o  = 1'b0;
        if (stall_i) begin
            npc_o = pc_i;
        end else if (op_i.c.jump) begin
            if (op_i.c.jreg) begin
                npc_o  = op_i.rs;
                jreg_o = 1'b1;
            end else begin
                npc_o  = abs_target(pc_i, op_i.jidx);
                jump_o = 1'b1;
            end
        end else if (op_i.c.branch && cond_i) begin
            npc_o   = pc_i + branch_ofs(op_i.imm);
            taken_o = 1'b1;
        end
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter bit DELAY_SLOT = 1'b0
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        stall_i,
    input  logic [31:0] pc_i,
    input  logic        jump_i,
    input  logic        jreg_i,
    input  logic        branch_i,
    input  logic        cmp_rt_i,
    input  logic        le_sel_i,
    input  logic        invert_i,
    input  logic        link_i,
    input  logic [25:0] jidx_i,
    input  logic [15:0] imm_i,
    input  logic [31:0] rs_i,
    input  logic [31:0] rt_i,
    output logic [31:0] npc_o,
    output logic        taken_o,
    output logic        jump_o,
    output logic        jreg_o,
    output logic        link_en_o,
    output logic [31:0] link_val_o
);

    op_t  live_op;
    op_t  app_op;
    logic cond;

    always_comb begin
        live_op.c.jump   = jump_i;
        live_op.c.jreg   = jreg_i;
        live_op.c.branch = branch_i;
        live_op.c.cmp_rt = cmp_rt_i;
        live_op.c.le_sel = le_sel_i;
        live_op.c.invert = invert_i;
        live_op.jidx     = jidx_i;
        live_op.imm      = imm_i;
        live_op.rs       = rs_i;
        live_op.rt       = rt_i;
    end

    npc_ctrl_sel #(.DELAY_SLOT(DELAY_SLOT)) u_sel (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .stall_i (stall_i),
        .op_i    (live_op),
        .op_o    (app_op)
    );

    npc_cond u_cond (
        .op_i   (app_op),
        .cond_o (cond)
    );

    npc_select u_next (
        .op_i    (app_op),
        .cond_i  (cond),
        .pc_i    (pc_i),
        .stall_i (stall_i),
        .npc_o   (npc_o),
        .taken_o (taken_o),
        .jump_o  (jump_o),
        .jreg_o  (jreg_o)
    );

    assign link_en_o  = link_i;
    assign link_val_o = pc_i + LINK_OFS;

    // R12
    one_redirect_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({taken_o, jump_o, jreg_o}));

    // R11
    stall_freeze_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_i |-> (npc_o == pc_i) && !taken_o && !jump_o && !jreg_o);

    // R2
    jump_region_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        jump_o |-> (npc_o[31:28] == pc_i[31:28]) && (npc_o[1:0] == 2'b00));

    // R1
    seq_advance_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && !taken_o && !jump_o && !jreg_o) |-> (npc_o - pc_i == 32'd4));

endmodule

// File: tb/sim_npc_unit.sv
module sim_npc_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stall = 1'b0;
    logic [31:0] pc = '0;
    logic [5:0]  ctl = '0;
    logic link = 1'b0;
    logic [25:0] jidx = '0;
    logic [15:0] imm = '0;
    logic [31:0] rs = '0;
    logic [31:0] rt = '0;

    logic [31:0] npc0, npc1, lv0, lv1;
    logic tk0, jp0, jr0, le0, tk1, jp1, jr1, le1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // ctl bit order: {jump, jreg, branch, cmp_rt, le_sel, invert}
    npc_unit #(.DELAY_SLOT(1'b0)) u0 (
        .clk_i(clk), .rst_i(rst), .stall_i(stall), .pc_i(pc),
        .jump_i(ctl[5]), .jreg_i(ctl[4]), .branch_i(ctl[3]), .cmp_rt_i(ctl[2]),
        .le_sel_i(ctl[1]), .invert_i(ctl[0]), .link_i(link),
        .jidx_i(jidx), .imm_i(imm), .rs_i(rs), .rt_i(rt),
        .npc_o(npc0), .taken_o(tk0), .jump_o(jp0), .jreg_o(jr0),
        .link_en_o(le0), .link_val_o(lv0));

    npc_unit #(.DELAY_SLOT(1'b1)) u1 (
        .clk_i(clk), .rst_i(rst), .stall_i(stall), .pc_i(pc),
        .jump_i(ctl[5]), .jreg_i(ctl[4]), .branch_i(ctl[3]), .cmp_rt_i(ctl[2]),
        .le_sel_i(ctl[1]), .invert_i(ctl[0]), .link_i(link),
        .jidx_i(jidx), .imm_i(imm), .rs_i(rs), .rt_i(rt),
        .npc_o(npc1), .taken_o(tk1), .jump_o(jp1), .jreg_o(jr1),
        .link_en_o(le1), .link_val_o(lv1));

    localparam logic [5:0] C_NONE = 6'b000000;
    localparam logic [5:0] C_J    = 6'b100000;
    localparam logic [5:0] C_JR   = 6'b110000;
    localparam logic [5:0] C_BEQ  = 6'b001100;
    localparam logic [5:0] C_BNE  = 6'b001101;
    localparam logic [5:0] C_BLTZ = 6'b001000;
    localparam logic [5:0] C_BLEZ = 6'b001010;
    localparam logic [5:0] C_BGTZ = 6'b001011;
    localparam logic [5:0] C_BGEZ = 6'b001001;
    localparam logic [5:0] C_JBEQ = 6'b101100;

    // kind: 0 sequential, 1 taken, 2 absolute jump, 3 register jump
    typedef struct packed {
        logic [5:0]  c;
        logic [31:0] pc;
        logic [25:0] jidx;
        logic [15:0] imm;
        logic [31:0] rs;
        logic [31:0] rt;
        logic [31:0] exp_npc;
        logic [1:0]  kind;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{C_NONE, 32'h0040_0000, 26'h0, 16'h0, 32'h9, 32'h9, 32'h0040_0004, 2'd0},
        '{C_J,    32'hA000_0010, 26'h012_3456, 16'h0, 32'h0, 32'h0, 32'hA048_D158, 2'd2},
        '{C_JR,   32'h0000_0100, 26'h0, 16'h0, 32'h1234_5678, 32'h0, 32'h1234_5678, 2'd3},
        '{C_BEQ,  32'h0000_1000, 26'h0, 16'h0010, 32'h5, 32'h5, 32'h0000_1040, 2'd1},
        '{C_BEQ,  32'h0000_1000, 26'h0, 16'h0010, 32'h5, 32'h6, 32'h0000_1004, 2'd0},
        '{C_BNE,  32'h0000_1000, 26'h0, 16'hFFFE, 32'h5, 32'h6, 32'h0000_0FF8, 2'd1},
        '{C_BNE,  32'h0000_1000, 26'h0, 16'hFFFE, 32'h5, 32'h5, 32'h0000_1004, 2'd0},
        '{C_BLTZ, 32'h0000_2000, 26'h0, 16'h0004, 32'hFFFF_FFFF, 32'h0, 32'h0000_2010, 2'd1},
        '{C_BLTZ, 32'h0000_2000, 26'h0, 16'h0004, 32'h0, 32'h0, 32'h0000_2004, 2'd0},
        '{C_BLEZ, 32'h0000_2000, 26'h0, 16'h0004, 32'h0, 32'h1, 32'h0000_2010, 2'd1},
        '{C_BLEZ, 32'h0000_2000, 26'h0, 16'h0004, 32'h7FFF_FFFF, 32'h0, 32'h0000_2004, 2'd0},
        '{C_BGTZ, 32'h0000_2000, 26'h0, 16'h0004, 32'h0, 32'h0, 32'h0000_2004, 2'd0},
        '{C_BGTZ, 32'h0000_2000, 26'h0, 16'h0004, 32'h1, 32'h0, 32'h0000_2010, 2'd1},
        '{C_BGEZ, 32'h0000_2000, 26'h0, 16'h0004, 32'h0, 32'h0, 32'h0000_2010, 2'd1},
        '{C_BGEZ, 32'h0000_2000, 26'h0, 16'h0004, 32'h8000_0000, 32'h0, 32'h0000_2004, 2'd0},
        '{C_BEQ,  32'h0010_0000, 26'h0, 16'h8000, 32'h0, 32'h0, 32'h000E_0000, 2'd1},
        '{C_JBEQ, 32'h3000_0000, 26'h10, 16'h0010, 32'h3, 32'h3, 32'h3000_0040, 2'd2},
        '{C_NONE, 32'hFFFF_FFFC, 26'h3FF_FFFF, 16'hFFFF, 32'h0, 32'h0, 32'h0000_0000, 2'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] kind_of(input logic t, input logic j, input logic r);
        return r ? 2'd3 : j ? 2'd2 : t ? 2'd1 : 2'd0;
    endfunction

    task automatic drive(input logic [5:0] c, input logic [31:0] p, input logic [25:0] ji,
                         input logic [15:0] im, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        ctl = c; pc = p; jidx = ji; imm = im; rs = a; rt = b;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R10: held control is a no-op right after reset
        chk(npc1 == 32'h0000_0004, "R10 npc after reset", npc1, 32'h4);
        chk(kind_of(tk1, jp1, jr1) == 2'd0, "R10 flags after reset", {30'b0, kind_of(tk1, jp1, jr1)}, 32'h0);

        // R1..R7, R12: table walk on the direct instance
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].c, VECS[i].pc, VECS[i].jidx, VECS[i].imm, VECS[i].rs, VECS[i].rt);
            chk(npc0 == VECS[i].exp_npc, $sformatf("R1-table vec %0d npc (R2 R3 R4 R5 R6 R7)", i), npc0, VECS[i].exp_npc);
            chk(kind_of(tk0, jp0, jr0) == VECS[i].kind, $sformatf("R12 vec %0d indicator", i),
                {30'b0, kind_of(tk0, jp0, jr0)}, {30'b0, VECS[i].kind});
            chk($countones({tk0, jp0, jr0}) <= 1, $sformatf("R12 vec %0d single indicator", i),
                {29'b0, tk0, jp0, jr0}, 32'h0);
        end

        // R8: link value in both settings
        drive(C_NONE, 32'h0000_0400, 26'h0, 16'h0, 32'h0, 32'h0);
        link = 1'b1;
        #1;
        chk(le0 && lv0 == 32'h0000_0408, "R8 link direct", lv0, 32'h408);
        chk(le1 && lv1 == 32'h0000_0408, "R8 link delayed", lv1, 32'h408);
        link = 1'b0;
        #1;
        chk(!le0 && !le1, "R8 link enable low", {30'b0, le0, le1}, 32'h0);

        // R9: delayed instance applies control one step later
        drive(C_JR, 32'h0000_0500, 26'h0, 16'h0, 32'hDEAD_0000, 32'h0);
        chk(npc1 == 32'h0000_0504, "R9 slot still sequential", npc1, 32'h504);
        chk(npc0 == 32'hDEAD_0000, "R3 direct register jump", npc0, 32'hDEAD_0000);
        drive(C_NONE, 32'h0000_0504, 26'h0, 16'h0, 32'h0, 32'h0);
        chk(npc1 == 32'hDEAD_0000 && jr1, "R9 delayed register jump", npc1, 32'hDEAD_0000);

        // R9 / R6: delayed branch uses next step pc
        drive(C_BEQ, 32'h0000_0600, 26'h0, 16'h0001, 32'h7, 32'h7);
        chk(npc1 == 32'h0000_0604, "R9 branch not yet applied", npc1, 32'h604);

        // R11: stall freezes pc and holds the pending branch
        drive(C_J, 32'h0000_0700, 26'h0000_ABC, 16'h0, 32'h0, 32'h0);
        stall = 1'b1;
        #1;
        chk(npc1 == 32'h0000_0700 && !tk1 && !jp1 && !jr1, "R11 stall delayed", npc1, 32'h700);
        chk(npc0 == 32'h0000_0700 && !tk0 && !jp0 && !jr0, "R11 stall direct", npc0, 32'h700);
        drive(C_JR, 32'h0000_0700, 26'h0, 16'h0, 32'h1111_1110, 32'h0);
        chk(npc1 == 32'h0000_0700, "R11 second stall step", npc1, 32'h700);
        drive(C_NONE, 32'h0000_0700, 26'h0, 16'h0, 32'h0, 32'h0);
        stall = 1'b0;
        #1;
        chk(npc1 == 32'h0000_0704 && tk1, "R11 held branch survives stall", npc1, 32'h704);

        // R10: reset mid-run discards pending jump
        drive(C_J, 32'h0000_0800, 26'h0000_123, 16'h0, 32'h0, 32'h0);
        rst = 1'b1;
        drive(C_NONE, 32'h0000_0800, 26'h0, 16'h0, 32'h0, 32'h0);
        rst = 1'b0;
        #1;
        chk(npc1 == 32'h0000_0804 && !jp1, "R10 reset clears pending", npc1, 32'h804);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule